// File: doc/BRIEF.md
# PCI Master DMA Burst Controller

This block sits beside a PCI bus master's DMA engine and decides two things: when the master should ask for the bus, and when an ongoing burst has to end. The bus request is driven by a programmable FIFO threshold. For a read from host memory, the threshold is compared with the number of bytes already held in the FIFO. For a write to host memory, it is compared with the free room in the FIFO. After a burst has been stopped, the request stays down until the threshold condition has gone false once. This keeps the master from re-arbitrating at once on the same fill level.

A burst ends for one of three reasons. The first is an expired latency timer while grant has been removed. In that case the end can be deferred to the last data phase of a cacheline, but only for cache-type read commands, and only when the matching option is on. The second is an optional cacheline stop for memory writes and write-and-invalidate. The third is a bus error. The block also holds the master-enable status bit. Hardware clears this bit on an abort, or on a parity error when stopping on parity errors is enabled. Software can write the bit back through a strobe. The block reports whether DMA may currently start, combining master-enable with the command-register enables.

Top module: `pci_dma_burst_ctl`

## Requirements
- R1: The 4-bit threshold code counts in 16-byte units (threshold = code × 16 bytes), and code 0 selects 256 bytes.
- R2: For a read (`xfer_dir` = 0), `bus_req` goes high one cycle after a cycle in which a transfer is active, DMA is allowed, and `fifo_level` is at least the threshold.
- R3: For a write (`xfer_dir` = 1), the same rule applies to the free space, `FIFO_DEPTH - fifo_level` (the depth defaults to 512 bytes).
- R4: If the latency timer has expired and grant is low while a transfer is active, `burst_stop` is high one cycle later. This holds unless R5 defers the stop.
- R5: When `cfg_lat_stop_line` is 1 and the command class is read-line (code 1) or read-multiple (code 2), the latency stop waits for the last dword of a cacheline. That dword is the one where `(cur_addr >> 2) mod line_dwords = line_dwords - 1`. A `line_dwords` of 0 makes every dword a boundary.
- R6: When `cfg_wr_stop_line` is 1, a burst with command memory-write (code 3) or write-and-invalidate (code 4) is stopped on the last dword of a cacheline. When the bit is 0, these commands are never stopped on a boundary. Command code 0 is a plain memory read.
- R7: `mst_en` is 1 after reset. One cycle after a master abort, a target abort, or a parity error with `cfg_stop_on_perr` set occurs during an active transfer, `mst_en` reads 0. A parity error with `cfg_stop_on_perr` clear leaves it unchanged.
- R8: A `mst_en_wr` strobe loads `mst_en_wdata` into `mst_en` on the next cycle. A hardware clear in the same cycle wins over the write.
- R9: `dma_allowed` equals `mst_en` AND `cmd_bus_master_en` AND (`cmd_io_en` OR `cmd_mem_en`). No request is raised from a cycle in which it is 0.
- R10: `bus_req` is low in every cycle in which `burst_stop` is high. After a stop, no request is raised until a cycle has passed in which the threshold condition was false.
- R11: An abort, or a parity error with `cfg_stop_on_perr` set, during an active transfer raises `burst_stop` one cycle later.
- R12: With `xfer_active` low, neither `bus_req` nor `burst_stop` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_thresh | input | 4 | Threshold code, 16-byte units, 0 = 256 bytes |
| cfg_lat_stop_line | input | 1 | Defer latency stops of cache reads to a cacheline end |
| cfg_wr_stop_line | input | 1 | Stop memory-write bursts on cacheline ends |
| cfg_stop_on_perr | input | 1 | Parity errors clear master-enable and stop the burst |
| cmd_bus_master_en | input | 1 | Command-register bus-master enable |
| cmd_io_en | input | 1 | Command-register I/O space enable |
| cmd_mem_en | input | 1 | Command-register memory space enable |
| mst_en_wr | input | 1 | Software write strobe for master-enable |
| mst_en_wdata | input | 1 | Value written to master-enable |
| xfer_active | input | 1 | A DMA transfer is in progress |
| xfer_dir | input | 1 | 0 = read from host, 1 = write to host |
| xfer_cmd | input | 3 | Command class: 0 read, 1 read-line, 2 read-multiple, 3 write, 4 write-invalidate |
| fifo_level | input | 10 | Bytes held in the FIFO |
| lat_expired | input | 1 | Latency timer has expired |
| bus_grant | input | 1 | Grant from the arbiter |
| cur_addr | input | 32 | Byte address of the current data phase |
| line_dwords | input | 8 | Cacheline size in dwords (power of two, 0 = one dword) |
| master_abort | input | 1 | Master abort seen |
| target_abort | input | 1 | Target abort seen |
| parity_err | input | 1 | Parity error seen |
| bus_req | output | 1 | Bus request, registered |
| burst_stop | output | 1 | End the current burst, registered |
| mst_en | output | 1 | Master-enable status bit |
| dma_allowed | output | 1 | DMA may start |

## Verification
`bus_req`, `burst_stop` and `mst_en` are all due exactly one clock after the input cycle that causes them. `dma_allowed` follows its inputs in the same cycle. The bench drives inputs just after a falling edge and updates a behavioural model on each rising edge from the inputs then present. It compares all four outputs at the next falling edge, so every check lands on the first cycle in which the result is due. Directed phases step through threshold edges, deferral versus immediate stop, hold-off after a stop, and enable priority. A random phase then mixes all inputs.

// File: rtl/pdbc_pkg.sv
package pdbc_pkg;

    typedef enum logic {
        DIR_TO_MASTER = 1'b0,
        DIR_TO_HOST   = 1'b1
    } xfer_dir_e;

    typedef enum logic [2:0] {
        CMD_RD      = 3'd0,
        CMD_RD_LINE = 3'd1,
        CMD_RD_MULT = 3'd2,
        CMD_WR      = 3'd3,
        CMD_WR_INV  = 3'd4
    } cmd_cls_e;

    typedef struct packed {
        logic lat_stop;
        logic line_wr_stop;
        logic err_stop;
    } stop_cause_t;

    localparam int THR_W = 9;

    function automatic logic [THR_W-1:0] thr_bytes(input logic [3:0] code);
        return (code == 4'd0) ? THR_W'(256) : {1'b0, code, 4'b0000};
    endfunction

    function automatic logic is_cache_read(input cmd_cls_e c);
        return (c == CMD_RD_LINE) || (c == CMD_RD_MULT);
    endfunction

    function automatic logic is_mem_write(input cmd_cls_e c);
        return (c == CMD_WR) || (c == CMD_WR_INV);
    endfunction

endpackage

// File: rtl/pdbc_enable_reg.sv
module pdbc_enable_reg (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic master_abort,
    input  logic target_abort,
    input  logic parity_err,
    input  logic stop_on_perr,
    input  logic sw_wr,
    input  logic sw_wdata,
    output logic hw_err,
    output logic mst_en
);
    logic clear_now;

    always_comb begin
        hw_err    = master_abort | target_abort | (parity_err & stop_on_perr);
        clear_now = active & hw_err;
    end

    always_ff @(posedge clk) begin
        if (rst)
            mst_en <= 1'b1;
        else if (clear_now)
            mst_en <= 1'b0;
        else if (sw_wr)
            mst_en <= sw_wdata;
    end

    p_hw_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (active && (master_abort || target_abort)) |=> !mst_en);

    p_sw_write_r8: assert property (@(posedge clk) disable iff (rst)
        (sw_wr && !active) |=> (mst_en == $past(sw_wdata)));

endmodule

// File: rtl/pdbc_stop_ctl.sv
module pdbc_stop_ctl
    import pdbc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LINE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  cmd_cls_e          cmd,
    input  logic              lat_expired,
    input  logic              grant,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LINE_W-1:0] line_dwords,
    input  logic              cfg_lat_line,
    input  logic              cfg_wr_line,
    input  logic              hw_err,
    output logic              stop_next,
    output logic              stop_q
);
    localparam logic [LINE_W-1:0] ONE = LINE_W'(1);

    logic [LINE_W-1:0] dw_index;
    logic [LINE_W-1:0] line_mask;
    logic [LINE_W-1:0] line_off;
    logic              line_end;
    logic              lat_hit;
    stop_cause_t       cause;

    genvar gi;
    generate
        for (gi = 0; gi < LINE_W; gi++) begin : g_idx
            assign dw_index[gi] = addr[gi+2];
        end
    endgenerate

    always_comb begin
        line_mask = line_dwords - ONE;
        line_off  = dw_index & line_mask;
        line_end  = (line_dwords == '0) || (line_off == line_mask);
        lat_hit   = lat_expired & ~grant;

        cause.lat_stop     = lat_hit &
                             ((cfg_lat_line & is_cache_read(cmd)) ? line_end : 1'b1);
        cause.line_wr_stop = cfg_wr_line & is_mem_write(cmd) & line_end;
        cause.err_stop     = hw_err;

        stop_next = active & (|cause);
    end

    always_ff @(posedge clk) begin
        if (rst)
            stop_q <= 1'b0;
        else
            stop_q <= stop_next;
    end

    p_idle_no_stop_r12: assert property (@(posedge clk) disable iff (rst)
        !active |=> !stop_q);

    p_defer_line_r5: assert property (@(posedge clk) disable iff (rst)
        (active && lat_expired && !grant && cfg_lat_line && is_cache_read(cmd)
         && !line_end && !hw_err) |=> !stop_q);

    p_immediate_r4: assert property (@(posedge clk) disable iff (rst)
        (active && lat_expired && !grant && !cfg_lat_line) |=> stop_q);

endmodule

// File: rtl/pdbc_req_gen.sv
module pdbc_req_gen
    import pdbc_pkg::*;
#(
    parameter int FIFO_DEPTH = 512,
    parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  xfer_dir_e        dir,
    input  logic [3:0]       thresh,
    input  logic [LVL_W-1:0] level,
    input  logic             allowed,
    input  logic             stop_next,
    input  logic             stop_q,
    output logic             bus_req
);
    localparam logic [LVL_W-1:0] DEPTH_V = LVL_W'(FIFO_DEPTH);

    logic [LVL_W-1:0] operand;
    logic [LVL_W-1:0] thr_v;
    logic             thr_met;
    logic             hold;
    logic             req_next;

    always_comb begin
        thr_v    = LVL_W'(thr_bytes(thresh));
        operand  = (dir == DIR_TO_HOST) ? (DEPTH_V - level) : level;
        thr_met  = (operand >= thr_v);
        req_next = active & allowed & thr_met & ~hold & ~stop_next;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold    <= 1'b0;
            bus_req <= 1'b0;
        end else begin
            bus_req <= req_next;
            if (stop_next)
                hold <= 1'b1;
            else if (!thr_met)
                hold <= 1'b0;
        end
    end

    p_req_not_with_stop_r10: assert property (@(posedge clk) disable iff (rst)
        !(bus_req && stop_q));

    p_no_req_unallowed_r9: assert property (@(posedge clk) disable iff (rst)
        !allowed |=> !bus_req);

    p_req_needs_thr_r2: assert property (@(posedge clk) disable iff (rst)
        !thr_met |=> !bus_req);

endmodule

// File: rtl/pci_dma_burst_ctl.sv
module pci_dma_burst_ctl
    import pdbc_pkg::*;
#(
    parameter int FIFO_DEPTH = 512,
    parameter int ADDR_W     = 32,
    parameter int LINE_W     = 8,
    parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        cfg_thresh,
    input  logic              cfg_lat_stop_line,
    input  logic              cfg_wr_stop_line,
    input  logic              cfg_stop_on_perr,
    input  logic              cmd_bus_master_en,
    input  logic              cmd_io_en,
    input  logic              cmd_mem_en,
    input  logic              mst_en_wr,
    input  logic              mst_en_wdata,
    input  logic              xfer_active,
    input  logic              xfer_dir,
    input  logic [2:0]        xfer_cmd,
    input  logic [LVL_W-1:0]  fifo_level,
    input  logic              lat_expired,
    input  logic              bus_grant,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [LINE_W-1:0] line_dwords,
    input  logic              master_abort,
    input  logic              target_abort,
    input  logic              parity_err,
    output logic              bus_req,
    output logic              burst_stop,
    output logic              mst_en,
    output logic              dma_allowed
);
    logic      hw_err;
    logic      stop_next;
    cmd_cls_e  cmd;
    xfer_dir_e dir;

    assign cmd         = cmd_cls_e'(xfer_cmd);
    assign dir         = xfer_dir_e'(xfer_dir);
    assign dma_allowed = mst_en & cmd_bus_master_en & (cmd_io_en | cmd_mem_en);

    pdbc_enable_reg u_en (
        .clk          (clk),
        .rst          (rst),
        .active       (xfer_active),
        .master_abort (master_abort),
        .target_abort (target_abort),
        .parity_err   (parity_err),
        .stop_on_perr (cfg_stop_on_perr),
        .sw_wr        (mst_en_wr),
        .sw_wdata     (mst_en_wdata),
        .hw_err       (hw_err),
        .mst_en       (mst_en)
    );

    pdbc_stop_ctl #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_stop (
        .clk          (clk),
        .rst          (rst),
        .active       (xfer_active),
        .cmd          (cmd),
        .lat_expired  (lat_expired),
        .grant        (bus_grant),
        .addr         (cur_addr),
        .line_dwords  (line_dwords),
        .cfg_lat_line (cfg_lat_stop_line),
        .cfg_wr_line  (cfg_wr_stop_line),
        .hw_err       (hw_err),
        .stop_next    (stop_next),
        .stop_q       (burst_stop)
    );

    pdbc_req_gen #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_req (
        .clk       (clk),
        .rst       (rst),
        .active    (xfer_active),
        .dir       (dir),
        .thresh    (cfg_thresh),
        .level     (fifo_level),
        .allowed   (dma_allowed),
        .stop_next (stop_next),
        .stop_q    (burst_stop),
        .bus_req   (bus_req)
    );

    p_err_stop_r11: assert property (@(posedge clk) disable iff (rst)
        (xfer_active && (master_abort || target_abort)) |=> (burst_stop && !bus_req));

endmodule

// File: tb/pci_dma_burst_ctl_test.sv
`timescale 1ns/1ps
module pci_dma_burst_ctl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  cfg_thresh = 4'd1;
    logic        cfg_lat_stop_line = 0, cfg_wr_stop_line = 0, cfg_stop_on_perr = 0;
    logic        cmd_bus_master_en = 1, cmd_io_en = 0, cmd_mem_en = 1;
    logic        mst_en_wr = 0, mst_en_wdata = 0;
    logic        xfer_active = 0, xfer_dir = 0;
    logic [2:0]  xfer_cmd = 3'd0;
    logic [9:0]  fifo_level = '0;
    logic        lat_expired = 0, bus_grant = 1;
    logic [31:0] cur_addr = '0;
    logic [7:0]  line_dwords = 8'd8;
    logic        master_abort = 0, target_abort = 0, parity_err = 0;
    logic        bus_req, burst_stop, mst_en, dma_allowed;

    int    n_tests = 0;
    int    n_fail  = 0;
    int    cycles  = 0;
    string tag     = "R7";

    // behavioural model state
    bit m_valid = 0;
    bit m_en = 1, m_hold = 0, e_req = 0, e_stop = 0;

    always #2.5 clk = ~clk;

    pci_dma_burst_ctl uut (
        .clk(clk), .rst(rst), .cfg_thresh(cfg_thresh),
        .cfg_lat_stop_line(cfg_lat_stop_line), .cfg_wr_stop_line(cfg_wr_stop_line),
        .cfg_stop_on_perr(cfg_stop_on_perr), .cmd_bus_master_en(cmd_bus_master_en),
        .cmd_io_en(cmd_io_en), .cmd_mem_en(cmd_mem_en), .mst_en_wr(mst_en_wr),
        .mst_en_wdata(mst_en_wdata), .xfer_active(xfer_active), .xfer_dir(xfer_dir),
        .xfer_cmd(xfer_cmd), .fifo_level(fifo_level), .lat_expired(lat_expired),
        .bus_grant(bus_grant), .cur_addr(cur_addr), .line_dwords(line_dwords),
        .master_abort(master_abort), .target_abort(target_abort), .parity_err(parity_err),
        .bus_req(bus_req), .burst_stop(burst_stop), .mst_en(mst_en), .dma_allowed(dma_allowed)
    );

    always @(posedge clk) begin
        int  thr, room;
        bit  met, allowed, cache_rd, wr_cmd, line_end, err, stop, req;
        thr      = (cfg_thresh == 0) ? 256 : int'(cfg_thresh) * 16;
        room     = xfer_dir ? (512 - int'(fifo_level)) : int'(fifo_level);
        met      = (room >= thr);
        allowed  = m_en && cmd_bus_master_en && (cmd_io_en || cmd_mem_en);
        cache_rd = (xfer_cmd == 1) || (xfer_cmd == 2);
        wr_cmd   = (xfer_cmd == 3) || (xfer_cmd == 4);
        line_end = (line_dwords == 0) ||
                   (((cur_addr >> 2) % line_dwords) == line_dwords - 1);
        err      = master_abort || target_abort || (parity_err && cfg_stop_on_perr);
        stop     = xfer_active && (err ||
                   (lat_expired && !bus_grant && (!(cfg_lat_stop_line && cache_rd) || line_end)) ||
                   (cfg_wr_stop_line && wr_cmd && line_end));
        req      = xfer_active && allowed && met && !m_hold && !stop;
        if (rst) begin
            e_req = 0; e_stop = 0; m_hold = 0; m_en = 1;
        end else begin
            e_req  = req;
            e_stop = stop;
            if (stop) m_hold = 1;
            else if (!met) m_hold = 0;
            if (xfer_active && err) m_en = 0;
            else if (mst_en_wr) m_en = mst_en_wdata;
        end
        m_valid = 1;
        cycles++;
    end

    task automatic cmp(input string what, input bit act, input bit exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0b expected %0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (m_valid) begin
            cmp("bus_req", bus_req, e_req);
            cmp("burst_stop", burst_stop, e_stop);
            cmp("mst_en", mst_en, m_en);
            cmp("dma_allowed", dma_allowed,
                m_en && cmd_bus_master_en && (cmd_io_en || cmd_mem_en));
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic quiet();
        xfer_active = 0; lat_expired = 0; bus_grant = 1;
        master_abort = 0; target_abort = 0; parity_err = 0;
        mst_en_wr = 0; fifo_level = 0;
    endtask

    always @(posedge clk) begin
        if (cycles > 20000) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // reset state: mst_en high, outputs low (R7)
        tag = "R7"; step(3);
        rst = 0; step(1);

        // R2 / R1: read threshold, code 4 = 64 bytes
        tag = "R2"; xfer_active = 1; xfer_dir = 0; xfer_cmd = 3'd1; cfg_thresh = 4'd4;
        fifo_level = 10'd63; step(2);
        fifo_level = 10'd64; step(2);
        tag = "R1"; cfg_thresh = 4'd0; fifo_level = 10'd255; step(2);
        fifo_level = 10'd256; step(2);

        // R3: write threshold on free space
        tag = "R3"; xfer_dir = 1; xfer_cmd = 3'd3; cfg_thresh = 4'd1;
        fifo_level = 10'd500; step(2);
        fifo_level = 10'd496; step(2);
        cfg_thresh = 4'd0; fifo_level = 10'd257; step(2);
        fifo_level = 10'd256; step(2);

        // R4: latency stop, immediate
        tag = "R4"; xfer_dir = 0; xfer_cmd = 3'd0; fifo_level = 10'd300;
        lat_expired = 1; bus_grant = 1; step(2);
        bus_grant = 0; step(2);
        // R10: hold after stop while threshold stays met
        tag = "R10"; lat_expired = 0; bus_grant = 1; step(3);
        fifo_level = 10'd10; step(1);
        fifo_level = 10'd300; step(2);

        // R5: deferred stop for cache reads
        tag = "R5"; cfg_lat_stop_line = 1; xfer_cmd = 3'd1; line_dwords = 8'd8;
        cur_addr = 32'h100; lat_expired = 1; bus_grant = 0; step(2);
        cur_addr = 32'h11C; step(1);
        xfer_cmd = 3'd2; cur_addr = 32'h104; step(2);
        xfer_cmd = 3'd0; step(2);
        line_dwords = 8'd0; xfer_cmd = 3'd1; step(2);
        lat_expired = 0; bus_grant = 1; cfg_lat_stop_line = 0; line_dwords = 8'd8;

        // R6: write cacheline stop
        tag = "R6"; xfer_dir = 1; fifo_level = 10'd0; xfer_cmd = 3'd4;
        cfg_wr_stop_line = 1; cur_addr = 32'h118; step(2);
        cur_addr = 32'h11C; step(2);
        xfer_cmd = 3'd3; step(1);
        cfg_wr_stop_line = 0; step(2);

        // R12: inactive transfer
        tag = "R12"; xfer_active = 0; lat_expired = 1; bus_grant = 0;
        cfg_wr_stop_line = 1; master_abort = 1; step(3);
        quiet(); cfg_wr_stop_line = 0;

        // R7: parity error handling
        tag = "R7"; xfer_active = 1; xfer_dir = 0; xfer_cmd = 3'd0; fifo_level = 10'd0;
        cfg_stop_on_perr = 0; parity_err = 1; step(2);
        tag = "R11"; cfg_stop_on_perr = 1; step(1);
        parity_err = 0; step(2);
        tag = "R9"; fifo_level = 10'd300; step(2);
        // R8: software rewrite and priority
        tag = "R8"; fifo_level = 10'd0; mst_en_wr = 1; mst_en_wdata = 1; step(1);
        mst_en_wr = 0; step(1);
        mst_en_wr = 1; mst_en_wdata = 1; target_abort = 1; step(1);
        mst_en_wr = 0; target_abort = 0; step(1);
        mst_en_wr = 1; step(1);
        mst_en_wr = 1; mst_en_wdata = 0; step(1);
        mst_en_wr = 1; mst_en_wdata = 1; step(1);
        mst_en_wr = 0;

        // R9: command-register gating
        tag = "R9"; fifo_level = 10'd300; cmd_bus_master_en = 0; step(3);
        cmd_bus_master_en = 1; cmd_mem_en = 0; cmd_io_en = 0; step(2);
        cmd_io_en = 1; step(3);
        cmd_mem_en = 1; cmd_io_en = 0;

        // R11: master abort mid-burst
        tag = "R11"; fifo_level = 10'd0; step(1);
        master_abort = 1; step(1); master_abort = 0; step(2);
        mst_en_wr = 1; mst_en_wdata = 1; step(1); mst_en_wr = 0;

        // mixed random traffic, all requirements
        tag = "R10";
        for (int k = 0; k < 1500; k++) begin
            xfer_active       = ($urandom_range(9, 0) != 0);
            xfer_dir          = $urandom_range(1, 0);
            xfer_cmd          = 3'($urandom_range(4, 0));
            cfg_thresh        = 4'($urandom_range(15, 0));
            fifo_level        = 10'($urandom_range(512, 0));
            lat_expired       = ($urandom_range(3, 0) == 0);
            bus_grant         = $urandom_range(1, 0);
            cur_addr          = $urandom;
            line_dwords       = 8'(1 << $urandom_range(4, 0));
            cfg_lat_stop_line = $urandom_range(1, 0);
            cfg_wr_stop_line  = $urandom_range(1, 0);
            cfg_stop_on_perr  = $urandom_range(1, 0);
            master_abort      = ($urandom_range(30, 0) == 0);
            target_abort      = ($urandom_range(30, 0) == 0);
            parity_err        = ($urandom_range(15, 0) == 0);
            mst_en_wr         = ($urandom_range(5, 0) == 0);
            mst_en_wdata      = ($urandom_range(3, 0) != 0);
            cmd_bus_master_en = ($urandom_range(15, 0) != 0);
            cmd_io_en         = $urandom_range(1, 0);
            cmd_mem_en        = ($urandom_range(3, 0) != 0);
            step(1);
        end
        quiet(); step(2);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule